// File: doc/BRIEF.md
# Serial Pad Configuration Chain

This block holds the electrical and ownership settings of a row of I/O pads. Each pad has one configuration cell. The cells are linked in a daisy chain, so that one serial data line, one shared serial clock and one active-low loader reset program every pad. Each cell has two registers. A shift register takes bits from the previous cell and passes its most significant bit on to the next cell. A settings register drives the pad. The settings register changes only when the loader reset is held low, or when it rises again. Shifting therefore never disturbs a pad that is in use.

The 13-bit word of each cell has the following layout, from MSB to LSB:

| Bit | Field | Meaning |
|---|---|---|
| 12 | `mgmt_en` | Ownership: 1 gives the pad to the management side, 0 to the user side |
| 11 | `oeb` | Output disable, active high |
| 10 | `holdover` | Hold-over |
| 9 | `inp_dis` | Input disable, active high |
| 8 | `ib_sel` | Input buffer mode |
| 7 | `ana_en` | Analog enable |
| 6 | `ana_sel` | Analog select |
| 5 | `ana_pol` | Analog polarity |
| 4 | `slow` | Slew select |
| 3 | `vtrip` | Trip-point select |
| 2:0 | `dm` | Drive mode |

The first `NUM_BIDIR` pads are bidirectional under management control. The remaining pads are input-type. When an input-type pad is owned by management, its output loops back from its own input. Its output disable then comes from the configured `oeb` bit.

The loader serial clock and the loader reset are sampled in the `clk` domain. Each must stay at a level for at least two `clk` cycles.

Top module: `pad_cfg_chain`

## Requirements
- R1: After a synchronous `rst`, every cell's settings and shift register hold its default word. Bidirectional pads (index < NUM_BIDIR) default to `mgmt_en`=1, `oeb`=1, `dm`=3'b110 (output, strong up/down). Input-type pads default to `mgmt_en`=1, `oeb`=1, `dm`=3'b001 (input). All other fields default to 0.
- R2: Each rising edge of `ld_sclk` shifts the whole chain by one bit. `ld_data` enters bit 0 of cell 0, and each cell's bit 12 enters bit 0 of the next cell. After N×13 shifts, cell c holds the word that was sent in position N-1-c, each word MSB first.
- R3: While `ld_resetn` stays high, shifting leaves every pad output unchanged.
- R4: While `ld_resetn` is low, every pad shows its R1 default, whatever was loaded before. On the rising edge of `ld_resetn`, each cell copies its shift register into its settings.
- R5: `ser_out` is bit 12 of the last cell's shift register. Each shift therefore presents the previously sent stream in the order it was sent, delayed by N×13 shifts.
- R6: On a bidirectional pad with `mgmt_en`=1, `pad_out` follows `mgmt_out`. `pad_oeb` is 0 when `mgmt_oeb` is 0, and is the configured `oeb` when `mgmt_oeb` is 1.
- R7: On an input-type pad with `mgmt_en`=1, `pad_out` follows that pad's `pad_in`, and `pad_oeb` equals the configured `oeb`.
- R8: With `mgmt_en`=0, `pad_out` and `pad_oeb` follow `user_out` and `user_oeb` of that pad.
- R9: `pad_in` is forwarded unchanged to both `user_in` and `mgmt_in`, whatever the configuration.
- R10: Each field of the settings drives its own pad output, at the bit position given in the word layout above.
- R11: After `rst`, a load strobe with no shifting reapplies the R1 defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_sclk | input | 1 | Loader serial clock; shifts on rising edge |
| ld_resetn | input | 1 | Loader reset: low forces defaults, rising edge applies |
| ld_data | input | 1 | Serial data into cell 0 |
| ser_out | output | 1 | Serial data out of the last cell |
| pad_in | input | NUM_PADS | Pad input values |
| pad_out | output | NUM_PADS | Pad output values |
| pad_oeb | output | NUM_PADS | Pad output disable (active high) |
| pad_inp_dis | output | NUM_PADS | Pad input disable (active high) |
| pad_dm | output | 3*NUM_PADS | Drive mode, 3 bits per pad |
| pad_holdover | output | NUM_PADS | Hold-over setting |
| pad_ib_sel | output | NUM_PADS | Input buffer mode |
| pad_ana_en | output | NUM_PADS | Analog enable |
| pad_ana_sel | output | NUM_PADS | Analog select |
| pad_ana_pol | output | NUM_PADS | Analog polarity |
| pad_slow | output | NUM_PADS | Slew select |
| pad_vtrip | output | NUM_PADS | Trip-point select |
| mgmt_out | input | NUM_BIDIR | Management output for bidirectional pads |
| mgmt_oeb | input | NUM_BIDIR | Management output disable for bidirectional pads |
| mgmt_in | output | NUM_PADS | Pad inputs to the management side |
| user_out | input | NUM_PADS | User output values |
| user_oeb | input | NUM_PADS | User output disables |
| user_in | output | NUM_PADS | Pad inputs to the user side |

## Verification
The hardest case to reach from the ports is a pull of the loader reset after user code has taken the pads, while the shift registers already hold a different, non-default stream. The pads must then fall back to management defaults and must not pick up the pending stream until the reset rises. The bench first loads several words in which ownership alternates between pads. It then shifts a new stream without a strobe and confirms that the old settings persist. Next it holds the reset low and checks the defaults on every pad output. On release it confirms that exactly the pending stream appears. Shifting zeros afterwards brings the stream back out of `ser_out` bit by bit, which shows the chain order.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;

    localparam int CFG_W = 13;
    localparam int DM_W  = 3;

    localparam logic [DM_W-1:0] DM_STRONG = 3'b110;
    localparam logic [DM_W-1:0] DM_INPUT  = 3'b001;

    typedef struct packed {
        logic            mgmt_en;
        logic            oeb;
        logic            holdover;
        logic            inp_dis;
        logic            ib_sel;
        logic            ana_en;
        logic            ana_sel;
        logic            ana_pol;
        logic            slow;
        logic            vtrip;
        logic [DM_W-1:0] dm;
    } pad_cfg_t;

    typedef struct packed {
        logic shift;
        logic load;
        logic hold;
    } loader_ev_t;

    function automatic pad_cfg_t dflt_cfg(input logic bidir);
        pad_cfg_t c;
        c         = '0;
        c.mgmt_en = 1'b1;
        c.oeb     = 1'b1;
        c.dm      = bidir ? DM_STRONG : DM_INPUT;
        return c;
    endfunction

endpackage

// File: rtl/pad_cfg_strobe.sv
module pad_cfg_strobe
    import pad_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ld_sclk,
    input  logic       ld_resetn,
    output loader_ev_t ev
);
    logic sclk_q;
    logic ldn_q;

    // Previous levels reset high, so no edge is seen on leaving reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b1;
            ldn_q  <= 1'b1;
        end else begin
            sclk_q <= ld_sclk;
            ldn_q  <= ld_resetn;
        end
    end

    always_comb begin
        ev.shift = ld_sclk & ~sclk_q;
        ev.load  = ld_resetn & ~ldn_q;
        ev.hold  = ~ld_resetn;
    end
endmodule

// File: rtl/pad_cfg_cell.sv
module pad_cfg_cell
    import pad_cfg_pkg::*;
#(
    parameter bit BIDIR = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  loader_ev_t ev,
    input  logic       ser_in,
    output logic       ser_out,
    input  logic       mgmt_o,
    input  logic       mgmt_oe_n,
    input  logic       user_o,
    input  logic       user_oe_n,
    output logic       pad_o,
    output logic       pad_oe_n,
    output pad_cfg_t   cfg,
    output pad_cfg_t   shadow
);
    localparam pad_cfg_t DFLT = dflt_cfg(BIDIR);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= DFLT;
        end else if (ev.shift) begin
            shadow <= {shadow[CFG_W-2:0], ser_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ev.hold) begin
            cfg <= DFLT;
        end else if (ev.load) begin
            cfg <= shadow;
        end
    end

    assign ser_out = shadow[CFG_W-1];

    always_comb begin
        if (cfg.mgmt_en) begin
            pad_o    = mgmt_o;
            pad_oe_n = mgmt_oe_n ? cfg.oeb : 1'b0;
        end else begin
            pad_o    = user_o;
            pad_oe_n = user_oe_n;
        end
    end
endmodule

// File: rtl/pad_cfg_chain.sv
module pad_cfg_chain
    import pad_cfg_pkg::*;
#(
    parameter int NUM_PADS  = 4,
    parameter int NUM_BIDIR = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ld_sclk,
    input  logic                      ld_resetn,
    input  logic                      ld_data,
    output logic                      ser_out,
    input  logic [NUM_PADS-1:0]       pad_in,
    output logic [NUM_PADS-1:0]       pad_out,
    output logic [NUM_PADS-1:0]       pad_oeb,
    output logic [NUM_PADS-1:0]       pad_inp_dis,
    output logic [DM_W*NUM_PADS-1:0]  pad_dm,
    output logic [NUM_PADS-1:0]       pad_holdover,
    output logic [NUM_PADS-1:0]       pad_ib_sel,
    output logic [NUM_PADS-1:0]       pad_ana_en,
    output logic [NUM_PADS-1:0]       pad_ana_sel,
    output logic [NUM_PADS-1:0]       pad_ana_pol,
    output logic [NUM_PADS-1:0]       pad_slow,
    output logic [NUM_PADS-1:0]       pad_vtrip,
    input  logic [NUM_BIDIR-1:0]      mgmt_out,
    input  logic [NUM_BIDIR-1:0]      mgmt_oeb,
    output logic [NUM_PADS-1:0]       mgmt_in,
    input  logic [NUM_PADS-1:0]       user_out,
    input  logic [NUM_PADS-1:0]       user_oeb,
    output logic [NUM_PADS-1:0]       user_in
);
    localparam int CHAIN_W = NUM_PADS * CFG_W;

    loader_ev_t           ev;
    logic [NUM_PADS:0]    link;
    logic [CHAIN_W-1:0]   cfg_flat;
    logic [CHAIN_W-1:0]   shadow_flat;

    pad_cfg_strobe u_strobe (
        .clk       (clk),
        .rst       (rst),
        .ld_sclk   (ld_sclk),
        .ld_resetn (ld_resetn),
        .ev        (ev)
    );

    assign link[0] = ld_data;
    assign ser_out = link[NUM_PADS];
    assign mgmt_in = pad_in;
    assign user_in = pad_in;

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
        logic     m_o;
        logic     m_oe_n;
        pad_cfg_t cfg;
        pad_cfg_t shadow;

        if (i < NUM_BIDIR) begin : g_bidir
            assign m_o    = mgmt_out[i];
            assign m_oe_n = mgmt_oeb[i];
        end else begin : g_input
            assign m_o    = pad_in[i];
            assign m_oe_n = 1'b1;
        end

        pad_cfg_cell #(
            .BIDIR (i < NUM_BIDIR)
        ) u_cell (
            .clk       (clk),
            .rst       (rst),
            .ev        (ev),
            .ser_in    (link[i]),
            .ser_out   (link[i+1]),
            .mgmt_o    (m_o),
            .mgmt_oe_n (m_oe_n),
            .user_o    (user_out[i]),
            .user_oe_n (user_oeb[i]),
            .pad_o     (pad_out[i]),
            .pad_oe_n  (pad_oeb[i]),
            .cfg       (cfg),
            .shadow    (shadow)
        );

        assign cfg_flat[i*CFG_W +: CFG_W]    = cfg;
        assign shadow_flat[i*CFG_W +: CFG_W] = shadow;
        assign pad_dm[i*DM_W +: DM_W]        = cfg.dm;
        assign pad_inp_dis[i]                = cfg.inp_dis;
        assign pad_holdover[i]               = cfg.holdover;
        assign pad_ib_sel[i]                 = cfg.ib_sel;
        assign pad_ana_en[i]                 = cfg.ana_en;
        assign pad_ana_sel[i]                = cfg.ana_sel;
        assign pad_ana_pol[i]                = cfg.ana_pol;
        assign pad_slow[i]                   = cfg.slow;
        assign pad_vtrip[i]                  = cfg.vtrip;
    end
endmodule

// File: rtl/pad_cfg_chain_chk.sv
module pad_cfg_chain_chk
    import pad_cfg_pkg::*;
#(
    parameter int NUM_PADS  = 4,
    parameter int NUM_BIDIR = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        ld_resetn,
    input logic                        ld_data,
    input loader_ev_t                  ev,
    input logic [NUM_PADS*CFG_W-1:0]   cfg_flat,
    input logic [NUM_PADS*CFG_W-1:0]   shadow_flat
);
    localparam int CHAIN_W = NUM_PADS * CFG_W;

    logic [CHAIN_W-1:0] dflt_flat;
    for (genvar i = 0; i < NUM_PADS; i++) begin : g_dflt
        assign dflt_flat[i*CFG_W +: CFG_W] = dflt_cfg(i < NUM_BIDIR);
    end

    p_reset_dflt_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_flat == dflt_flat && shadow_flat == dflt_flat))
        else $error("R1: state not at defaults after reset");

    p_chain_shift_r2: assert property (@(posedge clk) disable iff (rst)
        (ev.shift && !rst) |=>
            shadow_flat == {$past(shadow_flat[CHAIN_W-2:0]), $past(ld_data)})
        else $error("R2: chain did not shift by one bit");

    p_no_glitch_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ld_resetn) && $past(ld_resetn, 2)) |-> $stable(cfg_flat))
        else $error("R3: settings changed without a strobe");

    p_hold_dflt_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(ld_resetn) |-> cfg_flat == dflt_flat)
        else $error("R4: defaults not held while loader reset low");

    p_apply_r4: assert property (@(posedge clk) disable iff (rst)
        (ev.load && !rst) |=> cfg_flat == $past(shadow_flat))
        else $error("R4: strobe did not apply shift contents");
endmodule

bind pad_cfg_chain pad_cfg_chain_chk #(
    .NUM_PADS  (NUM_PADS),
    .NUM_BIDIR (NUM_BIDIR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ld_resetn   (ld_resetn),
    .ld_data     (ld_data),
    .ev          (ev),
    .cfg_flat    (cfg_flat),
    .shadow_flat (shadow_flat)
);

// File: tb/tb_pad_cfg_chain.sv
module tb_pad_cfg_chain;
    localparam int NP = 4;
    localparam int NB = 2;
    localparam int W  = 13;
    localparam int NW = NP * W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_sclk = 1'b0;
    logic ld_resetn = 1'b1;
    logic ld_data = 1'b0;
    logic ser_out;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oeb, pad_inp_dis, pad_holdover, pad_ib_sel;
    logic [NP-1:0] pad_ana_en, pad_ana_sel, pad_ana_pol, pad_slow, pad_vtrip;
    logic [3*NP-1:0] pad_dm;
    logic [NB-1:0] mgmt_out = '0;
    logic [NB-1:0] mgmt_oeb = '1;
    logic [NP-1:0] mgmt_in, user_in;
    logic [NP-1:0] user_out = '0;
    logic [NP-1:0] user_oeb = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [W-1:0]  cur [NP];
    logic [NW-1:0] sent;

    always #5 clk = ~clk;

    pad_cfg_chain #(.NUM_PADS(NP), .NUM_BIDIR(NB)) dut (
        .clk(clk), .rst(rst), .ld_sclk(ld_sclk), .ld_resetn(ld_resetn),
        .ld_data(ld_data), .ser_out(ser_out), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oeb(pad_oeb), .pad_inp_dis(pad_inp_dis),
        .pad_dm(pad_dm), .pad_holdover(pad_holdover), .pad_ib_sel(pad_ib_sel),
        .pad_ana_en(pad_ana_en), .pad_ana_sel(pad_ana_sel),
        .pad_ana_pol(pad_ana_pol), .pad_slow(pad_slow), .pad_vtrip(pad_vtrip),
        .mgmt_out(mgmt_out), .mgmt_oeb(mgmt_oeb), .mgmt_in(mgmt_in),
        .user_out(user_out), .user_oeb(user_oeb), .user_in(user_in)
    );

    function automatic logic [W-1:0] dflt_word(input int c);
        return 13'h1800 | ((c < NB) ? 13'd6 : 13'd1);
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected pad view built from the requirements (R6, R7, R8, R10).
    task automatic check_pad(input string tag, input int c, input logic [W-1:0] w);
        logic eo, eoe;
        logic [W-1:0] obs;
        if (w[12]) begin
            eo  = (c < NB) ? mgmt_out[c] : pad_in[c];
            eoe = (c < NB) ? (mgmt_oeb[c] ? w[11] : 1'b0) : w[11];
        end else begin
            eo  = user_out[c];
            eoe = user_oeb[c];
        end
        obs = {pad_oeb[c], pad_out[c], pad_holdover[c], pad_inp_dis[c], pad_ib_sel[c],
               pad_ana_en[c], pad_ana_sel[c], pad_ana_pol[c], pad_slow[c], pad_vtrip[c],
               pad_dm[c*3 +: 3]};
        check($sformatf("%s pad%0d", tag, c), {19'd0, obs}, {19'd0, eoe, eo, w[10:0]});
    endtask

    task automatic shift_bit(input logic b);
        ld_data = b;
        ld_sclk = 1'b1;
        wait_n(2);
        ld_sclk = 1'b0;
        wait_n(2);
    endtask

    task automatic shift_stream(input logic [NW-1:0] s);
        for (int k = 0; k < NW; k++) shift_bit(s[NW-1-k]);
    endtask

    task automatic strobe();
        ld_resetn = 1'b0;
        wait_n(3);
        ld_resetn = 1'b1;
        wait_n(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        pad_in   = 4'b1010;
        mgmt_out = 2'b01;
        mgmt_oeb = 2'b10;
        user_out = 4'b0110;
        user_oeb = 4'b0011;
        wait_n(3);
        rst = 1'b0;
        wait_n(2);

        // R1: defaults after reset; R5: ser_out shows last cell MSB (1)
        for (int c = 0; c < NP; c++) begin
            cur[c] = dflt_word(c);
            check_pad("R1 reset default", c, cur[c]);
        end
        check("R5 ser_out after reset", {31'd0, ser_out}, 32'd1);

        // Sweeps: R2, R3, R6, R7, R8, R10
        for (int s = 0; s < 6; s++) begin
            logic [W-1:0] w [NP];
            for (int c = 0; c < NP; c++) begin
                w[c] = 13'((c * 937 + s * 499 + 177) & 12'hFFF);
                w[c][12] = 1'((c + s) & 1);
                sent[c*W +: W] = w[c];
            end
            shift_stream(sent);
            for (int c = 0; c < NP; c++) check_pad("R3 before strobe", c, cur[c]);
            strobe();
            for (int c = 0; c < NP; c++) begin
                cur[c] = w[c];
                check_pad("R2 R6 R7 R8 R10 loaded", c, cur[c]);
            end
        end

        // R6: management output/disable combinations on bidirectional pads
        for (int m = 0; m < 4; m++) begin
            mgmt_out = 2'(m);
            mgmt_oeb = 2'(~m);
            wait_n(1);
            for (int c = 0; c < NB; c++) check_pad("R6 mgmt combo", c, cur[c]);
        end

        // R9 and R7: sweep every pad input pattern
        for (int p = 0; p < 16; p++) begin
            pad_in = 4'(p);
            wait_n(1);
            check("R9 user_in", {28'd0, user_in}, p);
            check("R9 mgmt_in", {28'd0, mgmt_in}, p);
            for (int c = NB; c < NP; c++) check_pad("R7 loopback", c, cur[c]);
        end

        // R4: pending stream plus loader reset held low after user takeover
        begin
            logic [NW-1:0] nxt;
            for (int c = 0; c < NP; c++) nxt[c*W +: W] = 13'h0AAA ^ 13'(c * 291);
            shift_stream(nxt);
            ld_resetn = 1'b0;
            wait_n(3);
            for (int c = 0; c < NP; c++) check_pad("R4 held low default", c, dflt_word(c));
            ld_resetn = 1'b1;
            wait_n(3);
            for (int c = 0; c < NP; c++) begin
                cur[c] = nxt[c*W +: W];
                check_pad("R4 release applies", c, cur[c]);
            end
            sent = nxt;
        end

        // R5: stream emerges from ser_out in sending order
        for (int k = 0; k < NW; k++) begin
            check($sformatf("R5 ser_out bit %0d", k), {31'd0, ser_out}, {31'd0, sent[NW-1-k]});
            shift_bit(1'b0);
        end
        for (int c = 0; c < NP; c++) check_pad("R3 after drain", c, cur[c]);

        // R11: reset then a bare strobe restores defaults
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
        wait_n(2);
        strobe();
        for (int c = 0; c < NP; c++) check_pad("R11 bare strobe", c, dflt_word(c));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule